// File: doc/BRIEF.md
# Processor Memory Bus Port

This block sits between a processor's internal data bus and an external memory that answers asynchronously. It holds two registers. The address register takes its value only from the internal bus and drives the external address lines. The data register can take a word from the internal bus or from the external read-data lines. It can also present its contents on the internal bus, on the external write-data lines, or on both. The enable for each of these paths is separate, and the control sequencer drives them one step at a time.

A step that raises the read or write request starts a memory cycle. The request strobe stays up until memory reports completion. That completion input is asynchronous, so it passes through a synchronizer before the block acts on it. A step that carries the wait control keeps the stall output high, and so freezes the sequencer, until the synchronized completion arrives. A load takes three steps: address to the address register with read; capture from memory while waiting; data register onto the internal bus. A store also takes three: address to the address register; data word into the data register with write; data register onto the external bus while waiting.

Top module: `membus_port`

## Requirements
- R1: After reset the address register and the data register read as zero, and `mem_rd`, `mem_wr`, `stall`, `ibus_oe` and `mem_wdata_oe` are low.
- R2: At a clock edge where `addr_ld` is high, the address register takes `ibus_in[ADDR_W-1:0]`. Otherwise it holds. `mem_addr` always shows the address register.
- R3: At a clock edge where `mdr_ld_int` is high, the data register takes `ibus_in`. This load takes priority over `mdr_ld_ext`.
- R4: With `mdr_ld_ext` high and `mdr_ld_int` low, the data register takes `mem_rdata` only at an edge where `stall` is low. While `stall` is high the data register keeps its value.
- R5: `ibus_out` equals the data register and `ibus_oe` is high while `mdr_drv_int` is high. Otherwise `ibus_out` is zero and `ibus_oe` is low. `mem_wdata` always equals the data register, and `mem_wdata_oe` follows `mdr_drv_ext`.
- R6: When no transfer is outstanding, `rd_req` raises `mem_rd` at the next edge and `wr_req` raises `mem_wr` at the next edge. If both are high, only the read starts. `mem_rd` and `mem_wr` are never high together.
- R7: An active strobe stays high until the synchronized completion is sampled high. It drops at that same edge.
- R8: `mem_done` passes through `SYNC_STAGES` flip-flops. With the default of two, the strobe falls at the third rising edge after `mem_done` rises.
- R9: `stall` is high exactly when `wait_cmp` is high, a strobe is active, and the synchronized completion is still low. A `wait_cmp` with no strobe active does not stall.
- R10: `rd_req` and `wr_req` are ignored while a strobe is active. They are also ignored after a strobe drops, until the synchronized completion has returned low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | DATA_W | Value currently on the internal bus |
| addr_ld | input | 1 | Load address register from internal bus |
| mdr_ld_int | input | 1 | Load data register from internal bus |
| mdr_ld_ext | input | 1 | Load data register from external read data |
| mdr_drv_int | input | 1 | Data register drives internal bus |
| mdr_drv_ext | input | 1 | Data register drives external write data |
| rd_req | input | 1 | Start a memory read |
| wr_req | input | 1 | Start a memory write |
| wait_cmp | input | 1 | Hold this step until memory completes |
| ibus_out | output | DATA_W | Data register value toward internal bus, zero when not driving |
| ibus_oe | output | 1 | Internal bus drive enable |
| stall | output | 1 | Freeze the control sequencer |
| mem_addr | output | ADDR_W | External address lines |
| mem_rd | output | 1 | External read strobe |
| mem_wr | output | 1 | External write strobe |
| mem_wdata | output | DATA_W | External write data |
| mem_wdata_oe | output | 1 | External write data drive enable |
| mem_rdata | input | DATA_W | External read data |
| mem_done | input | 1 | Asynchronous completion from memory |

## Verification
The embedded properties watch a fixed set of rules on every cycle:
- the two strobes are mutually exclusive;
- a strobe holds until the synchronized completion arrives and then drops;
- no strobe restarts while a transfer or its drain is in progress;
- the stall is raised only under a wait with a strobe active;
- the address register loads and holds as its enable says.

Other behaviour shows only in the bench's scenarios, where a memory with random latency runs:
- words read from memory reach the internal bus;
- stored words land in memory;
- the three-edge delay through the synchronizer holds;
- garbage on the read lines during a stall is not captured;
- requests issued during a wait or a drain are ignored.

// File: rtl/membus_pkg.sv
package membus_pkg;
   typedef enum logic [1:0] {
      XF_IDLE   = 2'd0,
      XF_ACTIVE = 2'd1,
      XF_DRAIN  = 2'd2
   } xfer_state_t;
endpackage

// File: rtl/membus_sync.sv
module membus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("membus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/membus_ctl.sv
module membus_ctl
   import membus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic wr_req,
   input  logic wait_cmp,
   input  logic done_s,
   output logic mem_rd,
   output logic mem_wr,
   output logic stall
);
   xfer_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= XF_IDLE;
         mem_rd <= 1'b0;
         mem_wr <= 1'b0;
      end else begin
         unique case (state)
            XF_IDLE: begin
               if (rd_req) begin
                  mem_rd <= 1'b1;
                  state  <= XF_ACTIVE;
               end else if (wr_req) begin
                  mem_wr <= 1'b1;
                  state  <= XF_ACTIVE;
               end
            end
            XF_ACTIVE: begin
               if (done_s) begin
                  mem_rd <= 1'b0;
                  mem_wr <= 1'b0;
                  state  <= XF_DRAIN;
               end
            end
            XF_DRAIN: begin
               if (!done_s) state <= XF_IDLE;
            end
            default: state <= XF_IDLE;
         endcase
      end
   end

   assign stall = wait_cmp && (state == XF_ACTIVE) && !done_s;

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !done_s) |=> $stable({mem_rd, mem_wr}));

   // R7
   strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && done_s) |=> (!mem_rd && !mem_wr));

   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != XF_IDLE) |=> (!$rose(mem_rd) && !$rose(mem_wr)));

   // R9
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (wait_cmp && (mem_rd || mem_wr)));
endmodule

// File: rtl/membus_mdr.sv
module membus_mdr #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ibus_in,
   input  logic              ld_int,
   input  logic              ld_ext,
   input  logic              ext_ok,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              drv_int,
   input  logic              drv_ext,
   output logic [DATA_W-1:0] ibus_out,
   output logic              ibus_oe,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_oe
);
   logic [DATA_W-1:0] mdr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                mdr_q <= '0;
      else if (ld_int)           mdr_q <= ibus_in;
      else if (ld_ext && ext_ok) mdr_q <= mem_rdata;
   end

   assign ibus_out     = drv_int ? mdr_q : '0;
   assign ibus_oe      = drv_int;
   assign mem_wdata    = mdr_q;
   assign mem_wdata_oe = drv_ext;

   // R4
   stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_int && !ext_ok) |=> $stable(mdr_q));
endmodule

// File: rtl/membus_port.sv
module membus_port #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ibus_in,
   input  logic              addr_ld,
   input  logic              mdr_ld_int,
   input  logic              mdr_ld_ext,
   input  logic              mdr_drv_int,
   input  logic              mdr_drv_ext,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              wait_cmp,
   output logic [DATA_W-1:0] ibus_out,
   output logic              ibus_oe,
   output logic              stall,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_oe,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("membus_port: widths must be positive");
      end
      if (ADDR_W > DATA_W) begin : g_bad_a
         $error("membus_port: ADDR_W must not exceed DATA_W");
      end
   endgenerate

   logic              done_s;
   logic [ADDR_W-1:0] mar_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mar_q <= '0;
      else if (addr_ld) mar_q <= ibus_in[ADDR_W-1:0];
   end
   assign mem_addr = mar_q;

   membus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (mem_done),
      .sync_out (done_s)
   );

   membus_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .wait_cmp (wait_cmp),
      .done_s   (done_s),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .stall    (stall)
   );

   membus_mdr #(.DATA_W(DATA_W)) u_mdr (
      .clk          (clk),
      .rst_n        (rst_n),
      .ibus_in      (ibus_in),
      .ld_int       (mdr_ld_int),
      .ld_ext       (mdr_ld_ext),
      .ext_ok       (!stall),
      .mem_rdata    (mem_rdata),
      .drv_int      (mdr_drv_int),
      .drv_ext      (mdr_drv_ext),
      .ibus_out     (ibus_out),
      .ibus_oe      (ibus_oe),
      .mem_wdata    (mem_wdata),
      .mem_wdata_oe (mem_wdata_oe)
   );

   // R2
   mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ld |=> $stable(mem_addr));

   // R2
   mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ld |=> (mem_addr == $past(ibus_in[ADDR_W-1:0])));
endmodule

// File: tb/membus_port_bench.sv
`timescale 1ns/1ps
module membus_port_bench;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NS = 2;

   localparam int C_ALD  = 0;
   localparam int C_LINT = 1;
   localparam int C_LEXT = 2;
   localparam int C_DINT = 3;
   localparam int C_DEXT = 4;
   localparam int C_RD   = 5;
   localparam int C_WR   = 6;
   localparam int C_WAIT = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] ibus_in = '0;
   logic [7:0] ctl = '0;
   logic [DW-1:0] ibus_out, mem_wdata;
   logic [DW-1:0] mem_rdata = 32'hDEAD_BEEF;
   logic [AW-1:0] mem_addr;
   logic ibus_oe, stall, mem_rd, mem_wr, mem_wdata_oe;
   logic mem_done = 1'b0;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   membus_port #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(NS)) u_membus_port (
      .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in),
      .addr_ld(ctl[C_ALD]), .mdr_ld_int(ctl[C_LINT]), .mdr_ld_ext(ctl[C_LEXT]),
      .mdr_drv_int(ctl[C_DINT]), .mdr_drv_ext(ctl[C_DEXT]),
      .rd_req(ctl[C_RD]), .wr_req(ctl[C_WR]), .wait_cmp(ctl[C_WAIT]),
      .ibus_out(ibus_out), .ibus_oe(ibus_oe), .stall(stall),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // reference model
   logic [AW-1:0] m_mar;
   logic [DW-1:0] m_mdr;
   logic m_rd, m_wr;
   int m_ph;
   logic [NS-1:0] m_sync;

   function automatic logic m_stall();
      return ctl[C_WAIT] && (m_ph == 1) && !m_sync[NS-1];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_mar = '0; m_mdr = '0; m_rd = 1'b0; m_wr = 1'b0; m_ph = 0; m_sync = '0;
      end else begin
         if (ctl[C_ALD]) m_mar = ibus_in[AW-1:0];
         if (ctl[C_LINT]) m_mdr = ibus_in;
         else if (ctl[C_LEXT] && !m_stall()) m_mdr = mem_rdata;
         if (m_ph == 0) begin
            if (ctl[C_RD]) begin m_rd = 1'b1; m_ph = 1; end
            else if (ctl[C_WR]) begin m_wr = 1'b1; m_ph = 1; end
         end else if (m_ph == 1) begin
            if (m_sync[NS-1]) begin m_rd = 1'b0; m_wr = 1'b0; m_ph = 2; end
         end else begin
            if (!m_sync[NS-1]) m_ph = 0;
         end
         m_sync = {m_sync[NS-2:0], mem_done};
      end
   end

   // compare every cycle, away from the edges
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         chk("R2 mem_addr", DW'(mem_addr), DW'(m_mar));
         chk("R3/R4/R5 ibus_out", ibus_out, ctl[C_DINT] ? m_mdr : '0);
         chk("R5 ibus_oe", DW'(ibus_oe), DW'(ctl[C_DINT]));
         chk("R5 mem_wdata", mem_wdata, m_mdr);
         chk("R5 mem_wdata_oe", DW'(mem_wdata_oe), DW'(ctl[C_DEXT]));
         chk("R6 mem_rd", DW'(mem_rd), DW'(m_rd));
         chk("R6 mem_wr", DW'(mem_wr), DW'(m_wr));
         chk("R9 stall", DW'(stall), DW'(m_stall()));
      end
   end

   // memory with random latency
   logic [DW-1:0] mem [16];
   int lat = 0;
   bit pend = 0;
   int rise_cyc = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_done = 1'b0; pend = 0;
      end else if (mem_done) begin
         if (!mem_rd && !mem_wr) begin
            chk("R7/R8 strobe fall delay", DW'(cyc - rise_cyc), DW'(NS + 1));
            mem_done = 1'b0;
            mem_rdata = 32'hDEAD_BEEF;
         end
      end else if (pend) begin
         lat--;
         if (lat == 0) begin
            if (mem_rd) mem_rdata = mem[mem_addr[5:2]];
            else        mem[mem_addr[5:2]] = mem_wdata;
            mem_done = 1'b1;
            rise_cyc = cyc;
            pend = 0;
         end
      end else if (mem_rd || mem_wr) begin
         pend = 1;
         lat = $urandom_range(1, 9);
      end
   end

   task automatic step(input logic [DW-1:0] bus, input logic [7:0] c);
      logic st;
      ibus_in = bus;
      ctl = c;
      do begin
         #1;
         st = stall;
         @(posedge clk);
         @(negedge clk);
      end while (st);
   endtask

   task automatic wait_idle();
      while (m_ph != 0) step('0, '0);
   endtask

   task automatic do_load(input logic [AW-1:0] a);
      step(DW'(a), 8'(1 << C_ALD) | 8'(1 << C_RD));
      step('0, 8'(1 << C_LEXT) | 8'(1 << C_WAIT));
      step('0, 8'(1 << C_DINT));
      #1;
      chk("R4 loaded word", ibus_out, mem[a[5:2]]);
      wait_idle();
   endtask

   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] v);
      step(DW'(a), 8'(1 << C_ALD));
      step(v, 8'(1 << C_LINT) | 8'(1 << C_WR));
      step('0, 8'(1 << C_DEXT) | 8'(1 << C_WAIT));
      chk("R5 stored word", mem[a[5:2]], v);
      wait_idle();
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 mem_addr", DW'(mem_addr), '0);
      chk("R1 mem_wdata", mem_wdata, '0);
      chk("R1 strobes", DW'({mem_rd, mem_wr, stall, ibus_oe, mem_wdata_oe}), '0);
      @(negedge clk);

      // R9: wait with nothing outstanding does not stall
      ctl = 8'(1 << C_WAIT);
      #1;
      chk("R9 idle wait", DW'(stall), '0);
      step('0, '0);

      // R3: internal load wins over external load
      mem_rdata = 32'h1234_5678;
      step(32'hCAFE_0001, 8'(1 << C_LINT) | 8'(1 << C_LEXT));
      step('0, 8'(1 << C_DINT));
      #1;
      chk("R3 priority", ibus_out, 32'hCAFE_0001);
      mem_rdata = 32'hDEAD_BEEF;

      for (int k = 0; k < 6; k++) do_store(AW'(k * 4), 32'hA500_0000 + k);
      for (int k = 0; k < 6; k++) do_load(AW'(k * 4));
      for (int k = 0; k < 10; k++) begin
         int a = $urandom_range(0, 15);
         if ($urandom_range(0, 1) == 1) do_store(AW'(a * 4), $urandom);
         else do_load(AW'(a * 4));
      end

      // R6: read wins when both requested
      step(32'h8, 8'(1 << C_ALD) | 8'(1 << C_RD) | 8'(1 << C_WR));
      #1;
      chk("R6 both requested rd", DW'(mem_rd), 32'd1);
      chk("R6 both requested wr", DW'(mem_wr), '0);
      // R10: write request during outstanding read ignored
      step('0, 8'(1 << C_WR));
      step('0, 8'(1 << C_WR) | 8'(1 << C_LEXT) | 8'(1 << C_WAIT));
      #1;
      chk("R10 no write after read", DW'(mem_wr), '0);
      // R10: request in drain ignored
      step('0, 8'(1 << C_RD));
      #1;
      chk("R10 drain ignores request", DW'(mem_rd), '0);
      wait_idle();
      step('0, 8'(1 << C_DINT));
      #1;
      chk("R4 word after busy sequence", ibus_out, mem[2]);
      step('0, '0);
      repeat (4) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule